// File: doc/BRIEF.md
# Branch Condition and Target Unit

This unit resolves a short-range conditional branch. Each cycle that `in_valid` is high it takes a 4-bit branch code, the four status flags (negative, zero, overflow, carry), the already-advanced program counter and an 8-bit signed displacement counted in words. One clock later it reports whether the branch is taken and the address the branch would reach.

The branch code has two fields. Bits [3:1] select one of eight base conditions, and bit 0 inverts the result. As a result, every test and its opposite differ only in the last bit. The base conditions are:

- always
- Z
- N
- V
- C
- N^V (signed less-than)
- Z|(N^V) (signed less-or-equal)
- C|Z (unsigned lower-or-same)

The unsigned tests lower and higher-or-same use the same codes as carry-set and carry-clear.

The target is always computed, whether or not the branch is taken. A fetch stage uses it only when `taken` is high, and otherwise carries on with the sequential address.

Top module: `brc_branch_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid`, `taken` and `target` are all zero after that edge.
- R2: A request sampled with `in_valid` high gives its result, with `out_valid` high, exactly one clock later. `out_valid` is low one clock after a cycle with `in_valid` low.
- R3: After a cycle with `in_valid` low, `taken` and `target` keep their previous values, whatever the other inputs do.
- R4: Code 0 is always taken and code 1 is never taken, for every flag combination.
- R5: The simple flag tests give taken = Z for code 2, !Z for code 3, N for code 4, !N for code 5, V for code 6, !V for code 7, C for code 8 and !C for code 9.
- R6: The signed tests give taken = N^V for code 10 (less-than), !(N^V) for code 11 (greater-or-equal), Z|(N^V) for code 12 (less-or-equal) and !(Z|(N^V)) for code 13 (greater-than).
- R7: The unsigned tests give taken = C|Z for code 14 (lower-or-same) and !C&!Z for code 15 (higher). Lower is code 8 and higher-or-same is code 9.
- R8: `target` equals `pc` plus twice the sign-extended `disp`, modulo 2^16. It is produced whether or not the branch is taken.
- R9: `disp` covers -128 to +127 words. The extremes give pc-256 and pc+254, and the sum wraps at both ends of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present this cycle |
| br_code | input | 4 | Condition select [3:1] and invert bit [0] |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| pc | input | 16 | Program counter already advanced past the branch |
| disp | input | 8 | Signed displacement in words |
| out_valid | output | 1 | Result present |
| taken | output | 1 | Branch condition met |
| target | output | 16 | Branch destination address |

## Verification
The assertions check on every cycle the reset values, the one-cycle latency of `out_valid`, the holding of results while idle, the fixed codes, the equal and signed less-than tests, and the target arithmetic. Only the bench's scenarios show that all sixteen codes give the right decision under every one of the sixteen flag combinations. The same applies to the extreme forward and backward displacements, the wrap-around at both ends of the address space, and the target produced for untaken branches.

// File: rtl/brc_pkg.sv
`timescale 1ns/1ps
package brc_pkg;
  localparam int CODE_W = 4;
  localparam int SEL_W  = CODE_W - 1;
  localparam int N_BASE = 1 << SEL_W;

  typedef enum logic [CODE_W-1:0] {
    BRC_ALWAYS = 4'd0,  BRC_NEVER = 4'd1,
    BRC_EQ     = 4'd2,  BRC_NE    = 4'd3,
    BRC_MI     = 4'd4,  BRC_PL    = 4'd5,
    BRC_VS     = 4'd6,  BRC_VC    = 4'd7,
    BRC_CS_LO  = 4'd8,  BRC_CC_HS = 4'd9,
    BRC_LT     = 4'd10, BRC_GE    = 4'd11,
    BRC_LE     = 4'd12, BRC_GT    = 4'd13,
    BRC_LOS    = 4'd14, BRC_HI    = 4'd15
  } br_code_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/brc_cond_eval.sv
`timescale 1ns/1ps
module brc_cond_eval
  import brc_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  flags_t            flags,
  output logic              cond_met
);
  logic [N_BASE-1:0] base;
  logic              lt_s;

  assign lt_s = flags.n ^ flags.v;

  always_comb begin
    base    = '0;
    base[0] = 1'b1;
    base[1] = flags.z;
    base[2] = flags.n;
    base[3] = flags.v;
    base[4] = flags.c;
    base[5] = lt_s;
    base[6] = flags.z | lt_s;
    base[7] = flags.c | flags.z;
  end

  // bit 0 of the code inverts the selected base condition
  assign cond_met = base[code[CODE_W-1:1]] ^ code[0];
endmodule

// File: rtl/brc_target_calc.sv
`timescale 1ns/1ps
module brc_target_calc #(
  parameter int ADDR_W     = 16,
  parameter int DISP_W     = 8,
  parameter int WORD_SHIFT = 1
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] target
);
  localparam int EXT_W = ADDR_W - DISP_W - WORD_SHIFT;

  logic [ADDR_W-1:0] offset;

  generate
    if (WORD_SHIFT == 0) begin : g_byte
      assign offset = {{EXT_W{disp[DISP_W-1]}}, disp};
    end else begin : g_scaled
      assign offset = {{EXT_W{disp[DISP_W-1]}}, disp, {WORD_SHIFT{1'b0}}};
    end
  endgenerate

  assign target = pc + offset;
endmodule

// File: rtl/brc_branch_unit.sv
`timescale 1ns/1ps
module brc_branch_unit
  import brc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DISP_W     = 8,
  parameter int WORD_SHIFT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        br_code,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_v,
  input  logic              flag_c,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DISP_W-1:0] disp,
  output logic              out_valid,
  output logic              taken,
  output logic [ADDR_W-1:0] target
);
  flags_t            flags;
  logic              cond_met;
  logic [ADDR_W-1:0] tgt_next;

  assign flags = '{n: flag_n, z: flag_z, v: flag_v, c: flag_c};

  brc_cond_eval u_cond (
    .code     (br_code),
    .flags    (flags),
    .cond_met (cond_met)
  );

  brc_target_calc #(
    .ADDR_W     (ADDR_W),
    .DISP_W     (DISP_W),
    .WORD_SHIFT (WORD_SHIFT)
  ) u_tgt (
    .pc     (pc),
    .disp   (disp),
    .target (tgt_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      target    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        taken  <= cond_met;
        target <= tgt_next;
      end
    end
  end
endmodule

// File: rtl/brc_branch_unit_chk.sv
`timescale 1ns/1ps
module brc_branch_unit_chk #(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [3:0]        br_code,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_v,
  input logic              flag_c,
  input logic [ADDR_W-1:0] pc,
  input logic [DISP_W-1:0] disp,
  input logic              out_valid,
  input logic              taken,
  input logic [ADDR_W-1:0] target
);
  logic [ADDR_W-1:0] exp_tgt;
  assign exp_tgt = pc + ADDR_W'({{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp} * 2);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && !taken && target == '0));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(taken) && $stable(target)));

  a_r4_always: assert property (@(posedge clk) disable iff (rst)
    (in_valid && br_code == 4'd0) |=> taken);

  a_r4_never: assert property (@(posedge clk) disable iff (rst)
    (in_valid && br_code == 4'd1) |=> !taken);

  a_r5_equal: assert property (@(posedge clk) disable iff (rst)
    (in_valid && br_code == 4'd2) |=> (taken == $past(flag_z)));

  a_r6_less: assert property (@(posedge clk) disable iff (rst)
    (in_valid && br_code == 4'd10) |=> (taken == ($past(flag_n) != $past(flag_v))));

  a_r8_target: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (target == $past(exp_tgt)));
endmodule

bind brc_branch_unit brc_branch_unit_chk #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .br_code(br_code),
  .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
  .pc(pc), .disp(disp), .out_valid(out_valid), .taken(taken), .target(target)
);

// File: tb/brc_branch_unit_tb.sv
`timescale 1ns/1ps
module brc_branch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  br_code = '0;
  logic        flag_n = 1'b0, flag_z = 1'b0, flag_v = 1'b0, flag_c = 1'b0;
  logic [15:0] pc = '0;
  logic [7:0]  disp = '0;
  logic        out_valid, taken;
  logic [15:0] target;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  brc_branch_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .br_code(br_code),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
    .pc(pc), .disp(disp), .out_valid(out_valid), .taken(taken), .target(target)
  );

  function automatic logic ref_taken(input logic [3:0] code, input logic [3:0] f);
    logic n, z, v, c;
    {n, z, v, c} = f;
    case (code)
      4'd0:  return 1'b1;
      4'd1:  return 1'b0;
      4'd2:  return z;
      4'd3:  return !z;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return c;
      4'd9:  return !c;
      4'd10: return n != v;
      4'd11: return n == v;
      4'd12: return z || (n != v);
      4'd13: return !z && (n == v);
      4'd14: return c || z;
      default: return !c && !z;
    endcase
  endfunction

  function automatic logic [15:0] ref_target(input logic [15:0] p, input logic [7:0] d);
    int s;
    s = int'(p) + 2 * int'($signed(d));
    return 16'(s);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive one request at a falling edge, check at the following falling edge
  task automatic apply(input string req, input logic [3:0] code, input logic [3:0] f,
                       input logic [15:0] p, input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    br_code  = code;
    {flag_n, flag_z, flag_v, flag_c} = f;
    pc   = p;
    disp = d;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, "out_valid", int'(out_valid), 1);
    check(req, "taken", int'(taken), int'(ref_taken(code, f)));
    check(req, "target", int'(target), int'(ref_target(p, d)));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "out_valid", int'(out_valid), 0);
    check("R1", "taken", int'(taken), 0);
    check("R1", "target", int'(target), 0);
    rst = 1'b0;
  endtask

  task automatic t_fixed_codes();   // R4
    for (int f = 0; f < 16; f++) begin
      apply("R4", 4'd0, 4'(f), 16'h1000, 8'h05);
      apply("R4", 4'd1, 4'(f), 16'h1000, 8'h05);
    end
  endtask

  task automatic t_simple();        // R5
    for (int code = 2; code < 10; code++)
      for (int f = 0; f < 16; f++)
        apply("R5", 4'(code), 4'(f), 16'(16'h2000 + f * 2), 8'(code));
  endtask

  task automatic t_signed();        // R6
    for (int code = 10; code < 14; code++)
      for (int f = 0; f < 16; f++)
        apply("R6", 4'(code), 4'(f), 16'h3000, 8'hF0);
  endtask

  task automatic t_unsigned();      // R7: 14, 15 and the aliases 8 (lower), 9 (higher-or-same)
    for (int f = 0; f < 16; f++) begin
      apply("R7", 4'd14, 4'(f), 16'h4000, 8'h10);
      apply("R7", 4'd15, 4'(f), 16'h4000, 8'h10);
      apply("R7", 4'd8,  4'(f), 16'h4000, 8'h10);
      apply("R7", 4'd9,  4'(f), 16'h4000, 8'h10);
    end
  endtask

  task automatic t_target();        // R8 untaken still gives target, R9 extremes and wrap
    apply("R8", 4'd1, 4'b0000, 16'h1234, 8'h22);
    apply("R8", 4'd2, 4'b0000, 16'h8000, 8'hFF);
    apply("R9", 4'd0, 4'b0000, 16'h5000, 8'h7F);
    check("R9", "fwd max", int'(target), 16'h50FE);
    apply("R9", 4'd0, 4'b0000, 16'h5000, 8'h80);
    check("R9", "back max", int'(target), 16'h4F00);
    apply("R9", 4'd0, 4'b0000, 16'hFFF0, 8'h10);
    check("R9", "wrap high", int'(target), 16'h0010);
    apply("R9", 4'd0, 4'b0000, 16'h0004, 8'hF0);
    check("R9", "wrap low", int'(target), 16'hFFE4);
  endtask

  task automatic t_hold();          // R2, R3
    logic        t_was;
    logic [15:0] g_was;
    apply("R3", 4'd2, 4'b0100, 16'h6000, 8'h03);
    t_was = taken;
    g_was = target;
    br_code = 4'd1;
    {flag_n, flag_z, flag_v, flag_c} = 4'b0000;
    pc = 16'hABCD;
    disp = 8'h80;
    repeat (3) @(negedge clk);
    check("R2", "out_valid idle", int'(out_valid), 0);
    check("R3", "taken held", int'(taken), int'(t_was));
    check("R3", "target held", int'(target), int'(g_was));
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_fixed_codes();
    t_simple();
    t_signed();
    t_unsigned();
    t_target();
    t_hold();
    t_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule